// File: doc/BRIEF.md
# Ethernet MAC Command Register

This block holds the 32-bit command word of an Ethernet MAC. A simple register bus writes the word in one cycle and reads it back at any time. The register drives the datapath's enable and mode inputs directly: transmit enable, receive enable, line loopback, broadcast filtering and pause-from-FIFO disable.

Three bits are commands rather than settings. A CRC-corrupt request stays pending until the transmitter signals the start of a frame, then damages the CRC of exactly that frame and clears. A counter-clear command sends a one-cycle request to the statistics logic and keeps reading as 1 until a done pulse returns. A software reset runs a short sequence. It forces both enables off, requests a statistics clear and a FIFO flush, waits until both have reported done, and then clears its bit. The mode bits keep their values through a software reset.

Top module: `mac_cmd_reg`

## Requirements
- R1: After hardware reset every register bit reads 0 and every output is 0.
- R2: Bit 0 (transmit enable), bit 1 (receive enable), bit 27 (line loopback), bit 28 (broadcast filter, 1 drops broadcasts) and bit 30 (pause-from-FIFO disable) are read/write. Each drives its output from the cycle after the write. All bits not named in these requirements read 0.
- R3: Writing 1 to bit 29 sets a pending flag that reads back at bit 29. `crc_corrupt` rises together with the first `tx_sof` pulse seen while the flag is set. The flag is then clear from the next cycle.
- R4: Writing 1 to bit 29 while a request is already pending adds no second corrupted frame.
- R5: Writing 1 to bit 31 raises `stat_clr_req` for exactly one cycle, in the cycle after the write. Bit 31 reads 1 until the cycle in which `stat_clr_done` is high, and reads 0 from the next cycle.
- R6: Writing 1 to bit 13 starts a software reset. Bit 13 reads 1 and both enables are 0 from the next cycle. Exactly one `fifo_flush_req` pulse and one `stat_clr_req` pulse follow.
- R7: Bit 13 clears by itself once both `fifo_flush_done` and `stat_clr_done` have been seen.
- R8: Bits 27, 28 and 30 keep their values through a software reset.
- R9: Register writes made while bit 13 reads 1 have no effect.
- R10: Each request output is high for one cycle only. A counter-clear command that arrives while a clear is outstanding does not issue a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| line_loop | output | 1 | Receive-to-transmit loopback |
| bcast_drop | output | 1 | Drop received broadcast frames |
| pause_fifo_off | output | 1 | Receive FIFO may not trigger pause frames |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| crc_corrupt | output | 1 | Corrupt the CRC of the frame starting now |
| stat_clr_req | output | 1 | One-cycle statistics clear request |
| stat_clr_done | input | 1 | Statistics clear finished |
| fifo_flush_req | output | 1 | One-cycle FIFO flush request |
| fifo_flush_done | input | 1 | FIFO flush finished |

## Verification
The assertions assume that a done input pulses only after its matching request and never in the same cycle as that request. They also assume that exactly one done answers each request. The bench stubs for the statistics counters and the FIFOs follow this rule. Each stub answers every request once, after a random delay of one to six cycles. Random writes leave out the command bits, so that pending commands appear only in the directed cases that check them.

// File: rtl/mac_cmd_pkg.sv
package mac_cmd_pkg;
    localparam int REG_W         = 32;
    localparam int BIT_TX_EN     = 0;
    localparam int BIT_RX_EN     = 1;
    localparam int BIT_SWRST     = 13;
    localparam int BIT_LOOP      = 27;
    localparam int BIT_BCAST     = 28;
    localparam int BIT_CRC_INJ   = 29;
    localparam int BIT_PAUSE_OFF = 30;
    localparam int BIT_CNT_CLR   = 31;

    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_ISSUE = 2'd1,
        SR_WAIT  = 2'd2
    } swrst_e;

    typedef struct packed {
        logic   tx_en;
        logic   rx_en;
        logic   loop;
        logic   bcast;
        logic   pause_off;
        swrst_e st;
    } cmd_state_t;
endpackage

// File: rtl/mac_cmd_handshake.sv
module mac_cmd_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic req,
    output logic busy
);
    typedef struct packed {
        logic req;
        logic busy;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (start && !q.busy) begin
            d.req  = 1'b1;
            d.busy = 1'b1;
        end else if (q.busy && !q.req && done) begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req  = q.req;
    assign busy = q.busy;

    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    p_busy_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/mac_cmd_crc_inject.sv
module mac_cmd_crc_inject (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic tx_sof,
    output logic pending,
    output logic corrupt
);
    logic pend_q, pend_d;

    always_comb begin
        pend_d = pend_q | set_req;
        if (tx_sof && pend_q) pend_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;
    assign corrupt = pend_q & tx_sof;

    p_crc_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        corrupt |=> !pending);
endmodule

// File: rtl/mac_cmd_reg.sv
module mac_cmd_reg
    import mac_cmd_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         tx_en,
    output logic         rx_en,
    output logic         line_loop,
    output logic         bcast_drop,
    output logic         pause_fifo_off,
    input  logic         tx_sof,
    output logic         crc_corrupt,
    output logic         stat_clr_req,
    input  logic         stat_clr_done,
    output logic         fifo_flush_req,
    input  logic         fifo_flush_done
);
    cmd_state_t q, d;
    logic wr_ok;
    logic stat_busy, flush_busy, crc_pend;
    logic stat_start, flush_start;

    assign wr_ok       = wr_en && (q.st == SR_IDLE);
    assign stat_start  = (wr_ok && wr_data[BIT_CNT_CLR]) || (q.st == SR_ISSUE);
    assign flush_start = (q.st == SR_ISSUE);

    always_comb begin
        d = q;
        case (q.st)
            SR_IDLE: begin
                if (wr_en) begin
                    d.tx_en     = wr_data[BIT_TX_EN];
                    d.rx_en     = wr_data[BIT_RX_EN];
                    d.loop      = wr_data[BIT_LOOP];
                    d.bcast     = wr_data[BIT_BCAST];
                    d.pause_off = wr_data[BIT_PAUSE_OFF];
                    if (wr_data[BIT_SWRST]) begin
                        d.st    = SR_ISSUE;
                        d.tx_en = 1'b0;
                        d.rx_en = 1'b0;
                    end
                end
            end
            SR_ISSUE: d.st = SR_WAIT;
            SR_WAIT:  if (!stat_busy && !flush_busy) d.st = SR_IDLE;
            default:  d.st = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tx_en: 1'b0, rx_en: 1'b0, loop: 1'b0, bcast: 1'b0,
                           pause_off: 1'b0, st: SR_IDLE};
        else        q <= d;
    end

    mac_cmd_handshake u_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .start(stat_start),
        .done (stat_clr_done),
        .req  (stat_clr_req),
        .busy (stat_busy)
    );

    mac_cmd_handshake u_flush (
        .clk  (clk),
        .rst_n(rst_n),
        .start(flush_start),
        .done (fifo_flush_done),
        .req  (fifo_flush_req),
        .busy (flush_busy)
    );

    mac_cmd_crc_inject u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(wr_ok && wr_data[BIT_CRC_INJ]),
        .tx_sof (tx_sof),
        .pending(crc_pend),
        .corrupt(crc_corrupt)
    );

    always_comb begin
        rd_data                = '0;
        rd_data[BIT_TX_EN]     = q.tx_en;
        rd_data[BIT_RX_EN]     = q.rx_en;
        rd_data[BIT_SWRST]     = (q.st != SR_IDLE);
        rd_data[BIT_LOOP]      = q.loop;
        rd_data[BIT_BCAST]     = q.bcast;
        rd_data[BIT_CRC_INJ]   = crc_pend;
        rd_data[BIT_PAUSE_OFF] = q.pause_off;
        rd_data[BIT_CNT_CLR]   = stat_busy;
    end

    assign tx_en          = q.tx_en;
    assign rx_en          = q.rx_en;
    assign line_loop      = q.loop;
    assign bcast_drop     = q.bcast;
    assign pause_fifo_off = q.pause_off;

    p_enables_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SR_IDLE) |-> (!tx_en && !rx_en));
    p_ignore_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SR_IDLE) |=> $stable({line_loop, bcast_drop, pause_fifo_off}));
    p_flush_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush_req |-> (q.st == SR_WAIT));
    p_wait_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == SR_WAIT) && (stat_busy || flush_busy)) |=> (q.st == SR_WAIT));
endmodule

// File: tb/sim_mac_cmd_reg.sv
module sim_mac_cmd_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tx_en, rx_en, line_loop, bcast_drop, pause_fifo_off;
    logic        tx_sof = 1'b0;
    logic        crc_corrupt, stat_clr_req, fifo_flush_req;
    logic        stat_clr_done = 1'b0, fifo_flush_done = 1'b0;

    int checks = 0, errors = 0;
    int n_stat = 0, n_flush = 0, n_crc = 0;
    logic [3:0] s_cd = '0, f_cd = '0;
    logic [3:0] s_lat = 4'd2, f_lat = 4'd3;
    bit finished = 0;

    localparam logic [31:0] RW_MASK = 32'h5800_0003;

    always #2 clk = ~clk;

    mac_cmd_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tx_en(tx_en), .rx_en(rx_en), .line_loop(line_loop),
        .bcast_drop(bcast_drop), .pause_fifo_off(pause_fifo_off), .tx_sof(tx_sof),
        .crc_corrupt(crc_corrupt), .stat_clr_req(stat_clr_req),
        .stat_clr_done(stat_clr_done), .fifo_flush_req(fifo_flush_req),
        .fifo_flush_done(fifo_flush_done)
    );

    // Stubs for the statistics and FIFO logic: one done per request.
    always @(posedge clk) begin
        stat_clr_done   <= 1'b0;
        fifo_flush_done <= 1'b0;
        if (stat_clr_req) begin
            n_stat <= n_stat + 1;
            s_cd   <= s_lat;
        end else if (s_cd != 0) begin
            s_cd <= s_cd - 1;
            if (s_cd == 1) stat_clr_done <= 1'b1;
        end
        if (fifo_flush_req) begin
            n_flush <= n_flush + 1;
            f_cd    <= f_lat;
        end else if (f_cd != 0) begin
            f_cd <= f_cd - 1;
            if (f_cd == 1) fifo_flush_done <= 1'b1;
        end
        if (crc_corrupt) n_crc <= n_crc + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [4:0] outs_of(input logic [31:0] v);
        return {v[0], v[1], v[27], v[28], v[30]};
    endfunction

    // Waits for bit 31 to drop, checking the cycle it falls (R5).
    task automatic wait_cnt_clr();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (stat_clr_done) begin
                check("R5 bit31 set in done cycle", {31'd0, rd_data[31]}, 32'd1);
                @(negedge clk);
                check("R5 bit31 clear after done", {31'd0, rd_data[31]}, 32'd0);
                break;
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] shadow;
        logic        pend;
        int          base;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset value", rd_data, 32'h0);
        check("R1 outputs idle",
              {27'd0, tx_en, rx_en, line_loop, bcast_drop, pause_fifo_off}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 value after release", rd_data, 32'h0);

        // R2: random plain read/write bits, reserved bits read 0
        for (int i = 0; i < 150; i++) begin
            logic [31:0] v;
            v = $urandom() & (RW_MASK | 32'h07FF_DFFC);
            v[13] = 1'b0;
            wr(v);
            check("R2 readback", rd_data, v & RW_MASK);
            check("R2 outputs",
                  {27'd0, tx_en, rx_en, line_loop, bcast_drop, pause_fifo_off},
                  {27'd0, outs_of(v)});
        end

        // R3/R4: random CRC requests and start-of-frame strobes
        shadow = 32'h0800_0001;
        wr(shadow);
        pend = 1'b0;
        for (int i = 0; i < 200; i++) begin
            logic w, s;
            w = ($urandom() % 4) == 0;
            s = ($urandom() % 3) == 0;
            @(negedge clk);
            wr_en   = w;
            wr_data = shadow | (w ? 32'h2000_0000 : 32'h0);
            tx_sof  = s;
            #1;
            check("R3 corrupt on sof", {31'd0, crc_corrupt}, {31'd0, s & pend});
            pend = (pend | w) & !(s & pend);
            @(negedge clk);
            wr_en  = 1'b0;
            tx_sof = 1'b0;
            #1;
            check("R3 pending readback", {31'd0, rd_data[29]}, {31'd0, pend});
        end
        if (pend) begin
            @(negedge clk); tx_sof = 1'b1;
            @(negedge clk); tx_sof = 1'b0;
        end

        // R4: a second request while pending adds no second error
        base = n_crc;
        wr(shadow | 32'h2000_0000);
        wr(shadow | 32'h2000_0000);
        check("R4 pending once", {31'd0, rd_data[29]}, 32'd1);
        repeat (3) begin
            @(negedge clk); tx_sof = 1'b1;
            @(negedge clk); tx_sof = 1'b0;
        end
        check("R4 single corrupted frame", n_crc - base, 32'd1);
        check("R3 bit29 cleared", {31'd0, rd_data[29]}, 32'd0);

        // R5/R10: counter clear command with a repeat while outstanding
        s_lat = 4'd6;
        base  = n_stat;
        @(negedge clk);
        wr_en = 1'b1; wr_data = shadow | 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 req pulse after write", {31'd0, stat_clr_req}, 32'd1);
        check("R5 bit31 reads 1", {31'd0, rd_data[31]}, 32'd1);
        @(negedge clk);
        check("R10 req single cycle", {31'd0, stat_clr_req}, 32'd0);
        wr(shadow | 32'h8000_0000);
        wait_cnt_clr();
        check("R10 one request only", n_stat - base, 32'd1);
        check("R5 config kept", rd_data, shadow & RW_MASK);

        // R6/R7/R8/R9: software reset with random handshake latencies
        for (int k = 0; k < 4; k++) begin
            logic [31:0] cfg;
            int bs, bf;
            s_lat = 4'(1 + $urandom() % 6);
            f_lat = 4'(1 + $urandom() % 6);
            cfg = ($urandom() & RW_MASK) | 32'h3;
            wr(cfg);
            bs = n_stat; bf = n_flush;
            wr(cfg | 32'h0000_2000);
            check("R6 swrst bit and enables off", rd_data, (cfg & 32'h5800_0000) | 32'h2000);
            check("R6 enable outputs off", {30'd0, tx_en, rx_en}, 32'd0);
            wr(32'h0000_0003 | (~cfg & 32'h5800_0000));
            check("R9 write ignored", rd_data & 32'h7FFF_FFFF,
                  (cfg & 32'h5800_0000) | 32'h2000);
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!rd_data[13]) break;
            end
            check("R7 swrst bit cleared", {31'd0, rd_data[13]}, 32'd0);
            check("R6 one flush request", n_flush - bf, 32'd1);
            check("R6 one stat clear request", n_stat - bs, 32'd1);
            check("R8 modes kept", rd_data, cfg & 32'h5800_0000);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule